// File: doc/BRIEF.md
# Qualified Pulse-Pattern Generator

This block is a small clocked sequencer that turns a level trigger into a four-clock bit pattern on a single output. When the trigger is seen high in the idle state, the output is driven high for one clock and then low for one clock. The third clock's value comes straight from a live qualifier input through gating logic, and the fourth is low. With the default polarity a low qualifier gives the pattern 1000 and a high qualifier gives 1010. A parameter flips the polarity so that a low qualifier gives 1010. Because the qualifier reaches the output through combinational logic and passes through no register, a change on it during the third clock appears on the output within that same clock.

After the pattern the machine waits until the trigger has been released. Holding the trigger high therefore yields exactly one pattern. The three state bits are brought out. They follow a unit-distance code, so each transition changes at most one bit. To keep the return to idle unit-distance as well, an optional drain state sits after the wait state and outside the pattern itself.

Top module: `qual_pattern_gen`

## Requirements
- R1: A synchronous active-high reset puts the state at 3'b000 (idle) with the pulse output low, including when it arrives in the middle of a pattern.
- R2: In idle (3'b000) with the trigger low, the state stays idle and the pulse output is 0.
- R3: In idle with the trigger high, the next clock edge moves the state to 3'b001, where the pulse output is 1.
- R4: From 3'b001 the state steps unconditionally to 3'b011 (pulse 0) and then to 3'b010. Each of these states lasts exactly one clock, whatever the trigger does.
- R5: With the polarity parameter at 0, the pulse output in state 3'b010 equals the qualifier input and follows it combinationally within the cycle.
- R6: With the polarity parameter at 1, the pulse output in state 3'b010 equals the inverse of the qualifier.
- R7: From 3'b010 the state moves to 3'b110 (pulse 0) and stays there while the trigger is high. No new pattern starts.
- R8: In 3'b110 with the trigger low, the state goes to the drain code 3'b100 if the drain parameter is 1, and then to idle on the next clock whatever the trigger is. If the drain parameter is 0, the state goes straight to idle.
- R9: With the drain state enabled, every clock edge outside reset changes at most one state bit.
- R10: The state output only ever holds one of the defined codes 000, 001, 011, 010, 110 or 100 (100 only with the drain enabled). Any other code returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Level trigger that starts a pattern |
| qual_i | input | 1 | Live qualifier for the third pattern bit |
| pulse_o | output | 1 | Pattern output, Mealy in the third bit |
| state_o | output | 3 | Current state code |

## Verification
The assertions check on every cycle the state-to-state walk, the hold in the wait state, the exit through the drain state, the legality of the state code, the unit-distance property and the qualifier gating in the third state. Only the bench's scenarios can show whole patterns across both qualifier values and both polarities, a qualifier flip in the middle of a cycle reaching the output, an early trigger release during the pattern, a long trigger hold that yields a single pattern, and a reset that cuts a pattern short.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_LEAD  = 3'b001,
        ST_GAP   = 3'b011,
        ST_QUAL  = 3'b010,
        ST_WAIT  = 3'b110,
        ST_DRAIN = 3'b100
    } qpg_state_e;

    typedef struct packed {
        qpg_state_e state;
    } qpg_regs_t;

    function automatic logic qpg_is_legal(input logic [ST_W-1:0] code, input bit drain_en);
        case (code)
            ST_IDLE, ST_LEAD, ST_GAP, ST_QUAL, ST_WAIT: return 1'b1;
            ST_DRAIN: return drain_en;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/qpg_seq.sv
module qpg_seq
    import qpg_pkg::*;
#(
    parameter bit DRAIN_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_i,
    output logic [ST_W-1:0] state_o
);
    qpg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_IDLE:  if (trig_i) regs_d.state = ST_LEAD;
            ST_LEAD:  regs_d.state = ST_GAP;
            ST_GAP:   regs_d.state = ST_QUAL;
            ST_QUAL:  regs_d.state = ST_WAIT;
            ST_WAIT: begin
                if (!trig_i) regs_d.state = DRAIN_EN ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: regs_d.state = ST_IDLE;
            default:  regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{state: ST_IDLE};
        else     regs_q <= regs_d;
    end

    assign state_o = regs_q.state;

    a_r3_launch: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && trig_i) |=> (state_o == ST_LEAD));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && !trig_i) |=> (state_o == ST_IDLE));
    a_r4_lead_step: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_LEAD) |=> (state_o == ST_GAP));
    a_r4_gap_step: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_GAP) |=> (state_o == ST_QUAL));
    a_r7_qual_to_wait: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_QUAL) |=> (state_o == ST_WAIT));
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WAIT && trig_i) |=> (state_o == ST_WAIT));
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WAIT && !trig_i) |=>
            (state_o == (DRAIN_EN ? ST_DRAIN : ST_IDLE)));
    a_r8_drain_exit: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DRAIN) |=> (state_o == ST_IDLE));
    a_r9_unit_step: assert property (@(posedge clk) disable iff (rst)
        (DRAIN_EN && !rst) |=> ($countones(state_o ^ $past(state_o)) <= 1));
    a_r10_legal: assert property (@(posedge clk) disable iff (rst)
        qpg_is_legal(state_o, DRAIN_EN));
endmodule

// File: rtl/qpg_outdec.sv
module qpg_outdec
    import qpg_pkg::*;
#(
    parameter bit QUAL_INVERT = 1'b0
) (
    input  logic [ST_W-1:0] state_i,
    input  logic            qual_i,
    output logic            pulse_o
);
    logic qual_eff;

    generate
        if (QUAL_INVERT) begin : g_inv
            assign qual_eff = ~qual_i;
        end else begin : g_pass
            assign qual_eff = qual_i;
        end
    endgenerate

    always_comb begin
        case (state_i)
            ST_LEAD: pulse_o = 1'b1;
            ST_QUAL: pulse_o = qual_eff;
            default: pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/qual_pattern_gen.sv
module qual_pattern_gen
    import qpg_pkg::*;
#(
    parameter bit QUAL_INVERT = 1'b0,
    parameter bit DRAIN_EN    = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_i,
    input  logic            qual_i,
    output logic            pulse_o,
    output logic [ST_W-1:0] state_o
);
    logic [ST_W-1:0] state_w;

    qpg_seq #(.DRAIN_EN(DRAIN_EN)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig_i),
        .state_o (state_w)
    );

    qpg_outdec #(.QUAL_INVERT(QUAL_INVERT)) u_outdec (
        .state_i (state_w),
        .qual_i  (qual_i),
        .pulse_o (pulse_o)
    );

    assign state_o = state_w;

    a_r5_qual_gate: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_QUAL) |-> (pulse_o == (qual_i ^ QUAL_INVERT)));
    a_r4_gap_low: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_GAP || state_w == ST_WAIT || state_w == ST_IDLE) |-> !pulse_o);
    a_r3_lead_high: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_LEAD) |-> pulse_o);
endmodule

// File: tb/qual_pattern_gen_bench.sv
module qual_pattern_gen_bench;
    logic clk = 1'b0;
    logic rst, trig, qual;
    logic pa, pb;
    logic [2:0] sa, sb;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    qual_pattern_gen #(.QUAL_INVERT(1'b0), .DRAIN_EN(1'b1)) u_qual_pattern_gen (
        .clk(clk), .rst(rst), .trig_i(trig), .qual_i(qual), .pulse_o(pa), .state_o(sa));

    qual_pattern_gen #(.QUAL_INVERT(1'b1), .DRAIN_EN(1'b0)) u_qual_pattern_gen_inv (
        .clk(clk), .rst(rst), .trig_i(trig), .qual_i(qual), .pulse_o(pb), .state_o(sb));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic legal(input logic [2:0] c, input bit drain);
        return (c == 3'b000 || c == 3'b001 || c == 3'b011 || c == 3'b010 ||
                c == 3'b110 || (drain && c == 3'b100));
    endfunction

    // Advance one edge and sample 5 ns later; also check code legality (R10)
    task automatic tick();
        @(posedge clk);
        #5;
        cyc++;
        chk("R10 legal code A", {3'b0, legal(sa, 1'b1)}, 4'd1);
        chk("R10 legal code B", {3'b0, legal(sb, 1'b0)}, 4'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; trig = 1'b0; qual = 1'b0;
        tick(); tick();
        chk("R1 reset state A", {1'b0, sa}, 4'b0000);
        chk("R1 reset pulse A", {3'b0, pa}, 4'd0);
        chk("R1 reset state B", {1'b0, sb}, 4'b0000);
        rst = 1'b0;

        for (int x = 0; x < 2; x++) begin
            for (int hold = 0; hold < 4; hold++) begin
                qual = x[0];
                tick(); tick();
                chk("R2 idle A", {pa, sa}, 4'b0000);
                chk("R2 idle B", {pb, sb}, 4'b0000);
                trig = 1'b1;
                tick();
                chk("R3 lead A", {pa, sa}, 4'b1001);
                chk("R3 lead B", {pb, sb}, 4'b1001);
                if (hold == 0) trig = 1'b0;   // early release must not cut the pattern (R4)
                tick();
                chk("R4 gap A", {pa, sa}, 4'b0011);
                chk("R4 gap B", {pb, sb}, 4'b0011);
                tick();
                chk("R5 qual A", {pa, sa}, {x[0], 3'b010});
                chk("R6 qual B", {pb, sb}, {~x[0], 3'b010});
                qual = ~x[0];
                #1;
                chk("R5 mid-cycle flip A", {3'b0, pa}, {3'b0, ~x[0]});
                chk("R6 mid-cycle flip B", {3'b0, pb}, {3'b0, x[0]});
                qual = x[0];
                #1;
                chk("R5 restore A", {3'b0, pa}, {3'b0, x[0]});
                tick();
                chk("R7 wait A", {pa, sa}, 4'b0110);
                chk("R7 wait B", {pb, sb}, 4'b0110);
                for (int k = 0; k < hold * 3; k++) begin
                    tick();
                    chk("R7 hold A", {pa, sa}, 4'b0110);
                    chk("R7 hold B", {pb, sb}, 4'b0110);
                end
                trig = 1'b0;
                tick();
                chk("R8 drain A", {pa, sa}, 4'b0100);
                chk("R8 direct idle B", {pb, sb}, 4'b0000);
                if (hold == 3) trig = 1'b1;   // trigger in drain does not skip idle
                tick();
                chk("R8 drain exit A", {pa, sa}, 4'b0000);
                if (hold == 3) begin
                    chk("R3 B restarts", {pb, sb}, 4'b1001);
                    tick();
                    chk("R3 A restarts from idle", {pa, sa}, 4'b1001);
                    trig = 1'b0;
                    rst = 1'b1;
                    tick();
                    chk("R1 mid-pattern reset A", {pa, sa}, 4'b0000);
                    chk("R1 mid-pattern reset B", {pb, sb}, 4'b0000);
                    rst = 1'b0;
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule